// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers level-sensitive interrupt requests from a fixed set of on-chip peripheral sources. It selects the most urgent request and gives the CPU that request's priority level and its vector code, together with a valid flag. A source may drive several request lines. Each line has its own vector, and every line of a source shares one mask bit and one 8-bit priority field. One mask bit may also cover several sources, so a whole group is gated together.

Software controls the block through a 32-bit register port. The port has one-cycle write and read strobes, a word address and write data. Two mask registers use write-one-to-set. Each has a companion register that uses write-one-to-clear. The priority registers hold four byte-wide fields each.

The source table is defined in the package, with eight sources and twenty request lines:

| Source | Lines | Vectors | Mask bit |
|---|---|---|---|
| s0 | line 0 | 0x580 | MASKA bit 0 |
| s1 | line 1 | 0x5A0 | MASKA bit 0 |
| s2 | line 2 | 0x5C0 | MASKA bit 0 |
| s3 | line 3 | 0x5E0 | MASKA bit 0 |
| s4 | lines 4 to 6 | from 0x480 | MASKA bit 2 |
| s5 | lines 7 to 11 | from 0x640 | MASKA bit 8 |
| s6 | lines 12 to 15 | from 0x700 | MASKA bit 3 |
| s7 | lines 16 to 19 | from 0xF80 | MASKB bit 1 |

Top module: `prio_vec_intc`

## Requirements
- R1: After reset, every implemented mask bit is set (all sources masked), every priority field is 0, and irq_valid is 0.
- R2: A write to MASKA (word address 0) or MASKB (word address 2) sets each implemented mask bit where the data has a 1. Bits written as 0 keep their value. A set mask bit blocks every request line mapped to it.
- R3: A write to the clear companion of MASKA (address 1) or of MASKB (address 3) clears each mask bit where the data has a 1. Zero bits leave the mask unchanged, and a read of either clear register returns 0.
- R4: Mask bit positions that no source uses always read as 0, and writes to them have no effect. The implemented bits are MASKA bits 0, 2, 3 and 8 (value 0x10D) and MASKB bit 1 (value 0x2).
- R5: Priority register PRIO0 (address 4) holds sources s0 to s3 and PRIO1 (address 5) holds s4 to s7. Within each register, the lowest-numbered source sits in bits [31:24], the next in [23:16], then [15:8], then [7:0]. Each register reads back as written.
- R6: A source whose priority field is 0 never produces a request, even when it is unmasked.
- R7: Among pending, unmasked, nonzero-priority lines, the one with the numerically highest priority is presented.
- R8: When pending lines have equal priority, the line with the lowest vector code is presented.
- R9: Line k of a source carries vector base + 0x20*k. All lines of a source share its mask bit and its priority.
- R10: Mask bit 0 of MASKA gates the four sources s0 to s3 together.
- R11: Outputs are registered. The values present before clock edge N set irq_valid, irq_level and irq_vector after edge N. When irq_valid is 0, level and vector are 0. Read data is valid in the cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| req_lines | input | 20 | Request levels, one per line |
| irq_valid | output | 1 | A request is being presented |
| irq_level | output | 8 | Priority of the presented request |
| irq_vector | output | 12 | Vector code of the presented request |

## Verification
A mask-register write and a change in request levels can land on the same clock edge. The selector sees the new request together with the mask that was in force before that edge. The bench raises a request of an unmasked source and, in the same cycle, writes the set register for that source's mask bit. It expects the request to be presented for exactly one cycle and to disappear in the cycle after. Group masking and priority ties on multi-line sources are also driven through a table of request patterns.

// File: rtl/pvi_pkg.sv
package pvi_pkg;
  localparam int NSRC   = 8;
  localparam int MAXL   = 5;
  localparam int PRIO_W = 8;
  localparam int VEC_W  = 12;
  localparam int REG_W  = 32;
  localparam int MASK_W = 64;
  localparam int FPR    = REG_W / PRIO_W;
  localparam int NPRIO  = (NSRC + FPR - 1) / FPR;
  localparam int VSTEP  = 32;

  typedef int src_tbl_t [NSRC];

  localparam src_tbl_t SRC_LINES = '{1, 1, 1, 1, 3, 5, 4, 4};
  localparam src_tbl_t SRC_VBASE = '{'h580, 'h5A0, 'h5C0, 'h5E0,
                                     'h480, 'h640, 'h700, 'hF80};
  localparam src_tbl_t SRC_MBIT  = '{0, 0, 0, 0, 2, 8, 3, 33};

  localparam int A_MSETA = 0;
  localparam int A_MCLRA = 1;
  localparam int A_MSETB = 2;
  localparam int A_MCLRB = 3;
  localparam int A_PRIO  = 4;

  function automatic int line_base(int s);
    int acc = 0;
    for (int i = 0; i < s; i++) acc += SRC_LINES[i];
    return acc;
  endfunction

  localparam int NLINES = line_base(NSRC);

  function automatic logic [MASK_W-1:0] used_bits();
    logic [MASK_W-1:0] u = '0;
    for (int s = 0; s < NSRC; s++) u[SRC_MBIT[s]] = 1'b1;
    return u;
  endfunction

  function automatic logic [REG_W-1:0] prio_keep(int r);
    logic [REG_W-1:0] k = '0;
    for (int j = 0; j < FPR; j++)
      if (r * FPR + j < NSRC) k[PRIO_W*(FPR-1-j) +: PRIO_W] = '1;
    return k;
  endfunction
endpackage

// File: rtl/pvi_regfile.sv
module pvi_regfile
  import pvi_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic                     rd_en,
  input  logic [AW-1:0]            addr,
  input  logic [REG_W-1:0]         wdata,
  output logic [REG_W-1:0]         rdata,
  output logic [MASK_W-1:0]        mask_o,
  output logic [NSRC*PRIO_W-1:0]   prio_flat
);
  localparam logic [MASK_W-1:0] USED  = used_bits();
  localparam logic [REG_W-1:0]  USEDA = USED[REG_W-1:0];
  localparam logic [REG_W-1:0]  USEDB = USED[MASK_W-1:REG_W];

  logic [REG_W-1:0] maska_q, maskb_q;
  logic [REG_W-1:0] prio_q [NPRIO];
  logic [REG_W-1:0] rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      maska_q <= USEDA;
      maskb_q <= USEDB;
    end else if (wr_en) begin
      case (addr)
        AW'(A_MSETA): maska_q <= maska_q | (wdata & USEDA);
        AW'(A_MCLRA): maska_q <= maska_q & ~wdata;
        AW'(A_MSETB): maskb_q <= maskb_q | (wdata & USEDB);
        AW'(A_MCLRB): maskb_q <= maskb_q & ~wdata;
        default: ;
      endcase
    end
  end

  for (genvar r = 0; r < NPRIO; r++) begin : g_prio
    localparam logic [REG_W-1:0] KEEP = prio_keep(r);
    always_ff @(posedge clk) begin
      if (rst) prio_q[r] <= '0;
      else if (wr_en && addr == AW'(A_PRIO + r)) prio_q[r] <= wdata & KEEP;
    end
  end

  for (genvar s = 0; s < NSRC; s++) begin : g_field
    assign prio_flat[PRIO_W*s +: PRIO_W] =
      prio_q[s / FPR][PRIO_W*(FPR-1-(s % FPR)) +: PRIO_W];
  end

  assign mask_o = {maskb_q, maska_q};

  always_comb begin
    rd_mux = '0;
    if (addr == AW'(A_MSETA)) rd_mux = maska_q;
    if (addr == AW'(A_MSETB)) rd_mux = maskb_q;
    for (int r = 0; r < NPRIO; r++)
      if (addr == AW'(A_PRIO + r)) rd_mux = prio_q[r];
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  AST_SET_STICKS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == AW'(A_MSETA)) |=> ((maska_q & $past(wdata) & USEDA) == ($past(wdata) & USEDA))); // R2
  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == AW'(A_MCLRA)) |=> ((maska_q & $past(wdata)) == '0)); // R3
  AST_CLR_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (addr == AW'(A_MCLRA) || addr == AW'(A_MCLRB))) |=> (rdata == '0)); // R3
  AST_PRIO_QUIET: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(prio_flat)); // R5
endmodule

// File: rtl/pvi_select.sv
module pvi_select
  import pvi_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NLINES-1:0]        req,
  input  logic [MASK_W-1:0]        mask,
  input  logic [NSRC*PRIO_W-1:0]   prio_flat,
  output logic                     valid,
  output logic [PRIO_W-1:0]        level,
  output logic [VEC_W-1:0]         vector
);
  logic              cand_act [NLINES];
  logic [PRIO_W-1:0] cand_lvl [NLINES];
  logic [VEC_W-1:0]  cand_vec [NLINES];

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    for (genvar k = 0; k < MAXL; k++) begin : g_line
      if (k < SRC_LINES[s]) begin : g_on
        localparam int IDX = line_base(s) + k;
        assign cand_lvl[IDX] = prio_flat[PRIO_W*s +: PRIO_W];
        assign cand_vec[IDX] = VEC_W'(SRC_VBASE[s] + VSTEP * k);
        assign cand_act[IDX] = req[IDX] && !mask[SRC_MBIT[s]] &&
                               (prio_flat[PRIO_W*s +: PRIO_W] != '0);
      end
    end
  end

  logic              best_act;
  logic [PRIO_W-1:0] best_lvl;
  logic [VEC_W-1:0]  best_vec;

  always_comb begin
    best_act = 1'b0;
    best_lvl = '0;
    best_vec = '0;
    for (int i = 0; i < NLINES; i++) begin
      if (cand_act[i] && (!best_act || cand_lvl[i] > best_lvl ||
          (cand_lvl[i] == best_lvl && cand_vec[i] < best_vec))) begin
        best_act = 1'b1;
        best_lvl = cand_lvl[i];
        best_vec = cand_vec[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid  <= 1'b0;
      level  <= '0;
      vector <= '0;
    end else begin
      valid  <= best_act;
      level  <= best_lvl;
      vector <= best_vec;
    end
  end

  AST_LEVEL_NONZERO: assert property (@(posedge clk) disable iff (rst)
    valid |-> (level != '0)); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !(|req) |=> !valid); // R11
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !valid |-> (level == '0 && vector == '0)); // R11
endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc
  import pvi_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic [AW-1:0]        reg_addr,
  input  logic [REG_W-1:0]     reg_wdata,
  output logic [REG_W-1:0]     reg_rdata,
  input  logic [NLINES-1:0]    req_lines,
  output logic                 irq_valid,
  output logic [PRIO_W-1:0]    irq_level,
  output logic [VEC_W-1:0]     irq_vector
);
  logic [MASK_W-1:0]      mask_w;
  logic [NSRC*PRIO_W-1:0] prio_w;

  pvi_regfile #(.AW(AW)) regs_i (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (reg_wr),
    .rd_en     (reg_rd),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .rdata     (reg_rdata),
    .mask_o    (mask_w),
    .prio_flat (prio_w)
  );

  pvi_select sel_i (
    .clk       (clk),
    .rst       (rst),
    .req       (req_lines),
    .mask      (mask_w),
    .prio_flat (prio_w),
    .valid     (irq_valid),
    .level     (irq_level),
    .vector    (irq_vector)
  );

  AST_RESET_MASKED: assert property (@(posedge clk)
    $past(rst) |-> !irq_valid); // R1
endmodule

// File: tb/prio_vec_intc_tb_top.sv
`timescale 1ns/1ps
module prio_vec_intc_tb_top;
  import pvi_pkg::*;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]        reg_addr = '0;
  logic [31:0]       reg_wdata = '0;
  logic [31:0]       reg_rdata;
  logic [NLINES-1:0] req_lines = '0;
  logic              irq_valid;
  logic [7:0]        irq_level;
  logic [11:0]       irq_vector;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  prio_vec_intc dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .req_lines(req_lines), .irq_valid(irq_valid),
    .irq_level(irq_level), .irq_vector(irq_vector)
  );

  // {req[19:0], valid, level[7:0], vector[11:0]}
  localparam logic [40:0] TBL [12] = '{
    {20'h00000, 1'b0, 8'd0,  12'h000},  // R11 idle
    {20'h00001, 1'b1, 8'd5,  12'h580},  // R7 single
    {20'h00003, 1'b1, 8'd5,  12'h580},  // R8 tie
    {20'h00006, 1'b1, 8'd7,  12'h5C0},  // R7 higher wins
    {20'h00008, 1'b0, 8'd0,  12'h000},  // R6 prio 0
    {20'h00020, 1'b1, 8'd10, 12'h4A0},  // R9 line 1 of s4
    {20'h00220, 1'b1, 8'd10, 12'h4A0},  // R8 tie across sources
    {20'h00A00, 1'b1, 8'd10, 12'h680},  // R9 multi-line tie
    {20'h10040, 1'b1, 8'd12, 12'hF80},  // R7
    {20'h02000, 1'b1, 8'd3,  12'h720},  // R9
    {20'h80000, 1'b1, 8'd12, 12'hFE0},  // R9 last line
    {20'hFFFFF, 1'b1, 8'd12, 12'hF80}   // R7 all
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 4'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = 4'(a);
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic drive_chk(input string tag, input logic [19:0] r,
                           input logic v, input logic [7:0] l, input logic [11:0] vec);
    @(negedge clk);
    req_lines = r;
    @(negedge clk);
    chk({tag, " valid"},  {31'd0, irq_valid}, {31'd0, v});
    chk({tag, " level"},  {24'd0, irq_level}, {24'd0, l});
    chk({tag, " vector"}, {20'd0, irq_vector}, {20'd0, vec});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 valid after reset", {31'd0, irq_valid}, 32'd0);
    rd(A_MSETA, d); chk("R1 R4 MASKA reset", d, 32'h0000010D);
    rd(A_MSETB, d); chk("R1 R4 MASKB reset", d, 32'h00000002);
    rd(A_PRIO, d);  chk("R1 PRIO0 reset", d, 32'h0);
    rd(A_PRIO+1, d); chk("R1 PRIO1 reset", d, 32'h0);
    // R1: masked after reset, even with priority written
    wr(A_PRIO, 32'h05050700);
    wr(A_PRIO+1, 32'h0A0A030C);
    drive_chk("R1 masked at reset", 20'h00001, 1'b0, 8'd0, 12'h000);
    rd(A_PRIO, d);   chk("R5 PRIO0 readback", d, 32'h05050700);
    rd(A_PRIO+1, d); chk("R5 PRIO1 readback", d, 32'h0A0A030C);
    wr(A_MCLRA, 32'hFFFFFFFF);
    wr(A_MCLRB, 32'hFFFFFFFF);
    rd(A_MSETA, d); chk("R3 MASKA cleared", d, 32'h0);
    rd(A_MCLRA, d); chk("R3 clear reg reads zero", d, 32'h0);

    for (int i = 0; i < 12; i++) begin
      drive_chk($sformatf("table row %0d", i), TBL[i][40:21], TBL[i][20],
                TBL[i][19:12], TBL[i][11:0]);
    end

    // R10 group mask
    wr(A_MSETA, 32'h00000001);
    drive_chk("R10 group masked, s6 wins", 20'h02005, 1'b1, 8'd3, 12'h720);
    drive_chk("R10 group masked alone", 20'h00002, 1'b0, 8'd0, 12'h000);
    // R3 / R2 zero writes
    wr(A_MCLRA, 32'h0);
    rd(A_MSETA, d); chk("R3 zero clear no effect", d, 32'h1);
    wr(A_MSETA, 32'h0);
    rd(A_MSETA, d); chk("R2 zero set no effect", d, 32'h1);
    // R4 unused bits
    wr(A_MSETB, 32'hFFFFFFFF);
    rd(A_MSETB, d); chk("R4 MASKB unused", d, 32'h2);
    drive_chk("R2 MASKB blocks s7", 20'h10000, 1'b0, 8'd0, 12'h000);
    wr(A_MSETA, 32'hFFFFFFFF);
    rd(A_MSETA, d); chk("R4 MASKA unused", d, 32'h10D);

    // R11 mask write and request in same cycle
    wr(A_MCLRA, 32'hFFFFFFFF);
    wr(A_MCLRB, 32'hFFFFFFFF);
    req_lines = '0;
    @(negedge clk);
    req_lines = 20'h02000;
    reg_wr = 1'b1; reg_addr = 4'(A_MSETA); reg_wdata = 32'h8;
    @(negedge clk);
    reg_wr = 1'b0;
    chk("R11 same-cycle first", {19'd0, irq_valid, irq_vector}, {19'd0, 1'b1, 12'h720});
    @(negedge clk);
    chk("R11 same-cycle second", {31'd0, irq_valid}, 32'd0);

    // R5 field position
    wr(A_PRIO+1, 32'h000000FF);
    drive_chk("R5 byte position", 20'h10010, 1'b1, 8'd255, 12'hF80);

    // R1 reset mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R1 valid after second reset", {31'd0, irq_valid}, 32'd0);
    rd(A_MSETA, d); chk("R1 MASKA after second reset", d, 32'h10D);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule